// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

This block watches the digital die-temperature samples of one core and turns them into interrupt events. Software programs two temperature trip levels. A pending event is raised whenever a new valid sample lands on the other side of a trip level from the sample before it. A direction bit records whether that last crossing went up or down.

The block also flags a sustained overheat. While throttling is active, it counts consecutive valid samples at or above a separate limit. When that run reaches a programmable length, it latches a sticky out-of-spec flag. A synchronised processor-hot input adds a pending event for each rising edge and for each falling edge.

Every pending bit sits in one status word that software clears by writing 1s. A single interrupt line is the OR of the pending bits whose enables are set.

Top module: `therm_thresh_mon`

## Requirements
- R1: After reset, `status_o` is 0 and `irq_o` is 0. Both trip levels reset to 0, all enables reset to 0, the limit resets to all ones and the run length resets to 16.
- R2: When a valid sample is at or above trip level k and the previous valid sample was below it, the block sets pend_k and sets dir_k to 1. The status bits are pend0=bit0, dir0=bit1, pend1=bit2 and dir1=bit3.
- R3: When a valid sample is below trip level k and the previous valid sample was at or above it, the block sets pend_k and clears dir_k to 0.
- R4: A sample that stays on the same side of a trip level as the previous valid sample raises no event. The first valid sample after reset raises no event.
- R5: A register write changes a trip level at once (address 0 for level 0, address 1 for level 1, data bits [7:0]). The write alone causes no event. Both the previous and the current sample are compared against the new level from the next valid sample on.
- R6: The out-of-spec flag (status bit4) is set on the valid sample that completes a run of N consecutive valid samples. Each sample in the run must have the throttle input high and a temperature at or above the limit. The limit is at address 3 and N is at address 4. A valid sample that fails the condition restarts the run.
- R7: The out-of-spec flag stays set after the condition ends, until software clears it.
- R8: A rising edge of the synchronised hot input sets status bit5. A falling edge sets status bit6.
- R9: `irq_o` is the OR of the pending bits masked by the enable register at address 2. Enable bit0 masks pend0, bit1 masks pend1, bit2 masks out-of-spec, bit3 masks the hot-rise event and bit4 masks the hot-fall event. A pending bit whose enable is clear does not drive `irq_o`.
- R10: A write to address 5 clears each pending bit (bits 0, 2, 4, 5 and 6) where the data bit is 1. Data bits that are 0 have no effect, and the direction bits are never changed by such a write.
- R11: Inputs presented while `smp_vld_i` is low are ignored. They do not change status and are not kept as the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Temperature sample strobe |
| temp_i | input | TEMP_W | Temperature sample |
| throttle_i | input | 1 | Throttling active (either kind) |
| hot_i | input | 1 | Asynchronous processor-hot level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | DATA_W | Register write data |
| status_o | output | 7 | Status word (pending and direction bits) |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded assertions check several things on every cycle:
- A pending or direction change happens only on a valid sample that has a previous valid sample to compare with.
- An upward direction always matches a sample at or above its trip level.
- The sticky flag never falls without a clear, and it rises only while throttling is active.
- Hot-edge events agree with the synchronised level.
- Trip levels stay unchanged between writes.

Only the bench scenarios can show the rest: the exact sequences of crossings and their directions, the run-length count and how a failing sample restarts it, that ignored samples are not used as history, and the masking and clearing of the interrupt.

// File: rtl/therm_mon_pkg.sv
package therm_mon_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_THR = 2;
  localparam int unsigned EN_W    = 5;
  localparam int unsigned STAT_W  = 7;

  localparam logic [ADDR_W-1:0] A_THR0   = 3'd0;
  localparam logic [ADDR_W-1:0] A_THR1   = 3'd1;
  localparam logic [ADDR_W-1:0] A_IRQ_EN = 3'd2;
  localparam logic [ADDR_W-1:0] A_LIMIT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RUNLEN = 3'd4;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd5;

  localparam int unsigned ST_OOS  = 4;
  localparam int unsigned ST_HOTR = 5;
  localparam int unsigned ST_HOTF = 6;

  localparam int unsigned EN_OOS  = 2;
  localparam int unsigned EN_HOTR = 3;
  localparam int unsigned EN_HOTF = 4;

  function automatic int unsigned st_pend(input int unsigned k);
    return 2 * k;
  endfunction

  function automatic int unsigned st_dir(input int unsigned k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/therm_regs.sv
module therm_regs
  import therm_mon_pkg::*;
#(
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned RUN_W    = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned RUN_DEF  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NUM_THR-1:0][TEMP_W-1:0] thr_o,
  output logic [EN_W-1:0]                en_o,
  output logic [TEMP_W-1:0]              limit_o,
  output logic [RUN_W-1:0]               run_len_o,
  output logic [STAT_W-1:0]              clr_o
);
  logic [NUM_THR-1:0][TEMP_W-1:0] thr_q;
  logic [EN_W-1:0]                en_q;
  logic [TEMP_W-1:0]              limit_q;
  logic [RUN_W-1:0]               run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q   <= '0;
      en_q    <= '0;
      limit_q <= '1;
      run_q   <= RUN_W'(RUN_DEF);
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_THR0:   thr_q[0] <= wr_data_i[TEMP_W-1:0];
        A_THR1:   thr_q[1] <= wr_data_i[TEMP_W-1:0];
        A_IRQ_EN: en_q     <= wr_data_i[EN_W-1:0];
        A_LIMIT:  limit_q  <= wr_data_i[TEMP_W-1:0];
        A_RUNLEN: run_q    <= wr_data_i[RUN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_o = '0;
    if (wr_en_i && wr_addr_i == A_STATUS) clr_o = wr_data_i[STAT_W-1:0];
  end

  assign thr_o     = thr_q;
  assign en_o      = en_q;
  assign limit_o   = limit_q;
  assign run_len_o = run_q;

  // R5
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(thr_q));
endmodule

// File: rtl/therm_cross.sv
module therm_cross #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              prev_vld_i,
  input  logic [TEMP_W-1:0] prev_temp_i,
  input  logic [TEMP_W-1:0] thr_i,
  input  logic              clr_i,
  output logic              pend_o,
  output logic              dir_o
);
  logic pend_q, dir_q;
  logic above_cur, above_prev, xing;

  // both sides use the live level, so a level write alone never crosses
  assign above_cur  = temp_i >= thr_i;
  assign above_prev = prev_temp_i >= thr_i;
  assign xing       = smp_vld_i && prev_vld_i && (above_cur != above_prev);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (xing) begin
      pend_q <= 1'b1;
      dir_q  <= above_cur;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign dir_o  = dir_q;

  // R4
  xing_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(smp_vld_i && prev_vld_i));

  // R2
  dir_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dir_q)) |-> $past(temp_i >= thr_i));

  // R3
  dir_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dir_q)) |-> $past(temp_i < thr_i));
endmodule

// File: rtl/therm_oos.sv
module therm_oos #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned RUN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              throttle_i,
  input  logic [TEMP_W-1:0] limit_i,
  input  logic [RUN_W-1:0]  run_len_i,
  input  logic              clr_i,
  output logic              sticky_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] cnt_q, cnt_inc;
  logic             hot_ok, sticky_q, hit;

  assign hot_ok  = throttle_i && (temp_i >= limit_i);
  assign cnt_inc = (cnt_q == RUN_MAX) ? cnt_q : cnt_q + 1'b1;
  assign hit     = smp_vld_i && hot_ok && (cnt_inc >= run_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (smp_vld_i) cnt_q <= hot_ok ? cnt_inc : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sticky_q <= 1'b0;
    else if (hit)    sticky_q <= 1'b1;
    else if (clr_i)  sticky_q <= 1'b0;
  end

  assign sticky_o = sticky_q;

  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sticky_q) |-> $past(clr_i));

  // R6
  oos_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky_q) |-> $past(throttle_i && smp_vld_i && temp_i >= limit_i));
endmodule

// File: rtl/therm_sync.sv
module therm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/therm_hot_edge.sv
module therm_hot_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic clr_rise_i,
  input  logic clr_fall_i,
  output logic rise_pend_o,
  output logic fall_pend_o
);
  logic last_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      last_q <= level_i;
      if (level_i && !last_q) rise_q <= 1'b1;
      else if (clr_rise_i)    rise_q <= 1'b0;
      if (!level_i && last_q) fall_q <= 1'b1;
      else if (clr_fall_i)    fall_q <= 1'b0;
    end
  end

  assign rise_pend_o = rise_q;
  assign fall_pend_o = fall_q;

  // R8
  hot_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rise_q) |-> $past(level_i));

  // R8
  hot_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fall_q) |-> !$past(level_i));
endmodule

// File: rtl/therm_thresh_mon.sv
module therm_thresh_mon
  import therm_mon_pkg::*;
#(
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned RUN_W       = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned RUN_DEF     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              throttle_i,
  input  logic              hot_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [6:0]        status_o,
  output logic              irq_o
);
  logic [NUM_THR-1:0][TEMP_W-1:0] thr;
  logic [EN_W-1:0]                en;
  logic [TEMP_W-1:0]              limit;
  logic [RUN_W-1:0]               run_len;
  logic [STAT_W-1:0]              clr;
  logic [NUM_THR-1:0]             pend, dir;
  logic                           oos, hot_lvl, hot_r, hot_f;
  logic [TEMP_W-1:0]              prev_temp_q;
  logic                           prev_vld_q;
  logic [STAT_W-1:0]              stat, mask;

  therm_regs #(
    .TEMP_W(TEMP_W), .RUN_W(RUN_W), .DATA_W(DATA_W), .RUN_DEF(RUN_DEF)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .thr_o(thr), .en_o(en), .limit_o(limit), .run_len_o(run_len), .clr_o(clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_temp_q <= '0;
      prev_vld_q  <= 1'b0;
    end else if (smp_vld_i) begin
      prev_temp_q <= temp_i;
      prev_vld_q  <= 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    therm_cross #(.TEMP_W(TEMP_W)) u_cross (
      .clk_i, .rst_ni, .smp_vld_i, .temp_i,
      .prev_vld_i(prev_vld_q), .prev_temp_i(prev_temp_q),
      .thr_i(thr[k]), .clr_i(clr[st_pend(k)]),
      .pend_o(pend[k]), .dir_o(dir[k])
    );
    assign stat[st_pend(k)] = pend[k];
    assign stat[st_dir(k)]  = dir[k];
    assign mask[st_pend(k)] = en[k];
    assign mask[st_dir(k)]  = 1'b0;
  end

  therm_oos #(.TEMP_W(TEMP_W), .RUN_W(RUN_W)) u_oos (
    .clk_i, .rst_ni, .smp_vld_i, .temp_i, .throttle_i,
    .limit_i(limit), .run_len_i(run_len), .clr_i(clr[ST_OOS]), .sticky_o(oos)
  );

  therm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(hot_i), .q_o(hot_lvl)
  );

  therm_hot_edge u_hot (
    .clk_i, .rst_ni, .level_i(hot_lvl),
    .clr_rise_i(clr[ST_HOTR]), .clr_fall_i(clr[ST_HOTF]),
    .rise_pend_o(hot_r), .fall_pend_o(hot_f)
  );

  assign stat[ST_OOS]  = oos;
  assign stat[ST_HOTR] = hot_r;
  assign stat[ST_HOTF] = hot_f;
  assign mask[ST_OOS]  = en[EN_OOS];
  assign mask[ST_HOTR] = en[EN_HOTR];
  assign mask[ST_HOTF] = en[EN_HOTF];

  assign status_o = stat;
  assign irq_o    = |(stat & mask);

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o != '0));
endmodule

// File: tb/therm_thresh_mon_tb_top.sv
module therm_thresh_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [7:0]  temp = '0;
  logic        thr_act = 1'b0;
  logic        hot = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  wa = '0;
  logic [15:0] wd = '0;
  logic [6:0]  status;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  therm_thresh_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .temp_i(temp),
    .throttle_i(thr_act), .hot_i(hot), .wr_en_i(we), .wr_addr_i(wa),
    .wr_data_i(wd), .status_o(status), .irq_o(irq)
  );

  // {temp[7:0], expected status[3:0]}; levels 50 and 80
  localparam logic [11:0] VEC_TAB [0:7] = '{
    12'h280, 12'h3C3, 12'h463, 12'h5AF, 12'h55F, 12'h4B7, 12'h1E5, 12'h327
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; wa = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic smp(input logic [7:0] t);
    @(negedge clk); vld = 1'b1; temp = t;
    @(negedge clk); vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    wr(3'd0, 16'd50);
    wr(3'd1, 16'd80);
    chk("R5 write alone", 32'(status), 32'h0);

    // R2 R3 R4 crossing table
    for (int i = 0; i < 8; i++) begin
      smp(VEC_TAB[i][11:4]);
      chk($sformatf("R2/R3/R4 vec%0d", i), 32'(status[3:0]), 32'(VEC_TAB[i][3:0]));
    end
    chk("R9 all masked", 32'(irq), 32'h0);

    // R10
    wr(3'd5, 16'h0000);
    chk("R10 zero write", 32'(status), 32'h07);
    wr(3'd5, 16'h000F);
    chk("R10 w1c keeps dir", 32'(status), 32'h02);

    // R11: unstrobed 100 would cross 80 if kept
    @(negedge clk); temp = 8'd100;
    repeat (3) @(negedge clk);
    chk("R11 unstrobed", 32'(status), 32'h02);
    smp(8'd50);
    chk("R11 history kept", 32'(status), 32'h02);

    // R5
    wr(3'd0, 16'd40);
    chk("R5 no event on write", 32'(status), 32'h02);
    smp(8'd50);
    chk("R5 same side", 32'(status), 32'h02);
    wr(3'd0, 16'd55);
    smp(8'd60);
    chk("R5 new level used", 32'(status), 32'h03);

    // R9
    wr(3'd2, 16'h0002);
    chk("R9 masked", 32'(irq), 32'h0);
    wr(3'd2, 16'h0001);
    chk("R9 enabled", 32'(irq), 32'h1);
    wr(3'd5, 16'h0001);
    chk("R9 cleared", 32'(irq), 32'h0);

    // R6
    wr(3'd3, 16'd100);
    wr(3'd4, 16'd4);
    for (int i = 0; i < 5; i++) smp(8'd110);
    chk("R6 no throttle", 32'(status[4]), 32'h0);
    thr_act = 1'b1;
    for (int i = 0; i < 3; i++) smp(8'd110);
    chk("R6 run of 3", 32'(status[4]), 32'h0);
    smp(8'd90);
    chk("R6 broken run", 32'(status[4]), 32'h0);
    for (int i = 0; i < 3; i++) smp(8'd110);
    chk("R6 restarted 3", 32'(status[4]), 32'h0);
    smp(8'd110);
    chk("R6 run of 4", 32'(status[4]), 32'h1);

    // R7
    thr_act = 1'b0;
    smp(8'd20);
    chk("R7 sticky", 32'(status[4]), 32'h1);
    wr(3'd5, 16'h0000);
    chk("R7 zero write", 32'(status[4]), 32'h1);
    wr(3'd2, 16'h0004);
    chk("R7 irq", 32'(irq), 32'h1);
    wr(3'd5, 16'h0010);
    chk("R7 cleared", 32'(status[4]), 32'h0);
    chk("R9 oos irq off", 32'(irq), 32'h0);

    // R8
    wr(3'd5, 16'h007F);
    wr(3'd2, 16'h0018);
    @(negedge clk); hot = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 rise", 32'(status[6:5]), 32'h1);
    chk("R8 rise irq", 32'(irq), 32'h1);
    wr(3'd5, 16'h0020);
    chk("R8 rise cleared", 32'(irq), 32'h0);
    @(negedge clk); hot = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 fall", 32'(status[6:5]), 32'h2);
    chk("R8 fall irq", 32'(irq), 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule